// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers 64 interrupt inputs into one registered interrupt request for a processor. Every input has its own control byte. The byte holds an enable bit and a two-bit trigger code. A source set to a level trigger shows its synchronized input directly as its status. A source set to an edge trigger latches each qualifying transition into a sticky pending bit, and software clears that bit with a write-one-to-clear access.

Among all sources that are both enabled and pending, an arbiter picks one winner. By default the lowest index wins. When rotating priority is switched on, the search starts just after the source that software last claimed, so that source becomes the lowest priority. Software reads the winner register to learn which source to service. A read of that register with the claim strobe high records the shown winner as claimed.

The register port is word-addressed, uses per-byte write enables, and returns read data combinationally. Register offsets are given below as byte offsets, which are the word address times 4.

Top module: `irq_trig_ctrl`

## Requirements
- R1: After reset the following all read zero: every control byte, both status words, the priority control word (0x20), the spare word (0x24) and the winner register (0x00). `irq_out` is low.
- R2: Source n's control byte sits in byte lane n mod 4 of the word at byte offset 0x40 + 4*(n div 4). A write changes only the lanes whose byte enable is set. Bit 3 of the byte is the enable, and bits 5:4 are the trigger code.
- R3: Trigger code 00 is active-high level. The source's status bit equals its input after a two-flop synchronizer, and writes to the status words do not clear it.
- R4: Trigger code 01 latches a rising edge, 10 latches a falling edge and 11 latches either edge into the source's status bit. Edges are detected after the two-flop synchronizer.
- R5: The status word at 0x80 holds sources 0 to 31 and the word at 0x84 holds sources 32 to 63, with source n at bit n mod 32. Writing 1 to a latched edge bit clears it. Writing 0 leaves it unchanged.
- R6: When an edge event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: A source whose enable bit is 0 never raises `irq_out` and is never chosen as winner. Its status bit is still recorded.
- R8: `irq_out` is registered. It is high one cycle after any source is both enabled and has its status bit set.
- R9: The read-only winner register at 0x00 holds the winner index in bits 5:0 and a valid flag in bit 7. With rotating priority off, the winner is the lowest-indexed enabled pending source. Writes to 0x00 have no effect.
- R10: Bit 6 of the word at 0x20 turns on rotating priority. A read of 0x00 with `reg_rd` high claims the shown winner. While rotation is on, the search starts at the index one above the last claimed source and wraps around from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 64 | Raw interrupt inputs, asynchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Read strobe; on the winner register it claims the shown winner |
| reg_waddr | input | 6 | Word address (byte offset divided by 4) |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_waddr, combinational |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A new edge on a source can be latched in the same cycle in which software writes a 1 to clear that source's status bit. The bench provokes this by timing a rising input so that the synchronized edge is detected in exactly the cycle that samples the clearing write. It then reads the status word, and the bit must still be set. A second overlap is a claiming read of the winner register while rotation is on. The bench checks that the winner moves from the claimed source to the other active source and then wraps back.

// File: rtl/irqc_pkg.sv
// Package: shared constants and types for the configurable-trigger
// interrupt controller. Assumes a fixed 64-source register map.
package irqc_pkg;
    localparam int NSRC      = 64;
    localparam int ID_W      = $clog2(NSRC);
    localparam int WA_W      = 6;
    localparam int LANES     = 4;
    localparam int EN_BIT    = 3;
    localparam int ROT_BIT   = 6;

    localparam logic [WA_W-1:0] WA_WINNER = 6'd0;   // byte 0x00
    localparam logic [WA_W-1:0] WA_PRIO   = 6'd8;   // byte 0x20
    localparam logic [WA_W-1:0] WA_AUX    = 6'd9;   // byte 0x24
    localparam logic [WA_W-1:0] WA_CTRL0  = 6'd16;  // byte 0x40
    localparam logic [WA_W-1:0] WA_STAT0  = 6'd32;  // byte 0x80
    localparam logic [WA_W-1:0] WA_STAT1  = 6'd33;  // byte 0x84

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_ANY   = 2'b11
    } trig_e;
endpackage

// File: rtl/irqc_src_cell.sv
// Module: one interrupt source. Synchronizes the raw input with two flops,
// detects edges against a third flop, and keeps a sticky pending bit for the
// edge triggers. Assumes the caller supplies a one-cycle clear strobe.
// A set in the same cycle as a clear wins.
module irqc_src_cell
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  src_in,
    input  trig_e mode,
    input  logic  clr,
    output logic  status,
    output logic  edge_pend
);
    logic s1_q, s2_q, prev_q, evt;

    // Two-flop synchronizer plus history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= src_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Qualify the synchronized transition by the selected trigger.
    always_comb begin
        case (mode)
            TRIG_RISE: evt = s2_q & ~prev_q;
            TRIG_FALL: evt = ~s2_q & prev_q;
            TRIG_ANY:  evt = s2_q ^ prev_q;
            default:   evt = 1'b0;
        endcase
    end

    // Sticky edge pending bit: clear by write, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_pend <= 1'b0;
        else        edge_pend <= (edge_pend & ~clr) | evt;
    end

    assign status = (mode == TRIG_LEVEL) ? s2_q : edge_pend;
endmodule

// File: rtl/irqc_regfile.sv
// Module: register file. Holds the per-source control bytes, the priority
// word and the spare word, builds the status clear strobes, and muxes read
// data. Assumes word addressing and per-lane byte enables.
module irqc_regfile
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [WA_W-1:0]      reg_waddr,
    input  logic [LANES-1:0]     reg_be,
    input  logic [31:0]          reg_wdata,
    input  logic [NSRC-1:0]      status,
    input  logic                 win_valid,
    input  logic [ID_W-1:0]      win_id,
    output logic [NSRC-1:0]      en_vec,
    output trig_e                mode_vec [NSRC],
    output logic [NSRC-1:0]      clr_vec,
    output logic                 rotate_en,
    output logic [31:0]          reg_rdata
);
    logic [7:0]  ctrl_q [NSRC];
    logic [31:0] prio_q, aux_q, bemask;

    // Expand byte enables into a bit mask.
    always_comb begin
        for (int b = 0; b < LANES; b++) bemask[b*8 +: 8] = {8{reg_be[b]}};
    end

    for (genvar n = 0; n < NSRC; n++) begin : g_ctrl
        localparam logic [WA_W-1:0] WA = WA_W'(int'(WA_CTRL0) + n / LANES);
        localparam int LN = n % LANES;
        // Control byte write for this source's lane.
        always_ff @(posedge clk) begin
            if (!rst_n) ctrl_q[n] <= 8'h00;
            else if (reg_wr && reg_waddr == WA && reg_be[LN])
                ctrl_q[n] <= reg_wdata[LN*8 +: 8];
        end
        assign en_vec[n]   = ctrl_q[n][EN_BIT];
        assign mode_vec[n] = trig_e'(ctrl_q[n][5:4]);
    end

    // Priority and spare words with byte-lane writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            aux_q  <= '0;
        end else if (reg_wr) begin
            if (reg_waddr == WA_PRIO) prio_q <= (prio_q & ~bemask) | (reg_wdata & bemask);
            if (reg_waddr == WA_AUX)  aux_q  <= (aux_q  & ~bemask) | (reg_wdata & bemask);
        end
    end

    assign rotate_en = prio_q[ROT_BIT];

    // One-cycle write-one-to-clear strobes for the two status words.
    always_comb begin
        clr_vec[31:0]  = (reg_wr && reg_waddr == WA_STAT0) ? (reg_wdata & bemask) : 32'h0;
        clr_vec[63:32] = (reg_wr && reg_waddr == WA_STAT1) ? (reg_wdata & bemask) : 32'h0;
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = 32'h0;
        if (reg_waddr[5:4] == 2'b01) begin
            reg_rdata = {ctrl_q[{reg_waddr[3:0], 2'b11}], ctrl_q[{reg_waddr[3:0], 2'b10}],
                         ctrl_q[{reg_waddr[3:0], 2'b01}], ctrl_q[{reg_waddr[3:0], 2'b00}]};
        end else begin
            case (reg_waddr)
                WA_WINNER: reg_rdata = {24'h0, win_valid, 1'b0, win_id};
                WA_PRIO:   reg_rdata = prio_q;
                WA_AUX:    reg_rdata = aux_q;
                WA_STAT0:  reg_rdata = status[31:0];
                WA_STAT1:  reg_rdata = status[63:32];
                default:   reg_rdata = 32'h0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Module: picks one enabled pending source, either by lowest index or by a
// rotating search that starts after the last claimed source. Registers the
// request, the valid flag and the winner index. Assumes claim is only
// asserted while the registered winner is valid.
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] active,
    input  logic            rotate_en,
    input  logic            claim,
    output logic            irq_q,
    output logic            win_valid_q,
    output logic [ID_W-1:0] win_id_q
);
    logic [ID_W-1:0] last_q, start, off, pick;
    logic [NSRC-1:0] rot;
    logic            found;

    assign start = rotate_en ? last_q + 1'b1 : '0;
    assign rot   = (active >> start) | (active << (7'(NSRC) - {1'b0, start}));

    // Lowest set bit of the rotated vector.
    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (rot[i]) begin
                found = 1'b1;
                off   = ID_W'(i);
            end
        end
    end

    assign pick = start + off;

    // Registered request and winner outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q       <= 1'b0;
            win_valid_q <= 1'b0;
            win_id_q    <= '0;
        end else begin
            irq_q       <= |active;
            win_valid_q <= found;
            win_id_q    <= found ? pick : '0;
        end
    end

    // Remember the last claimed winner for rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= '1;
        else if (claim) last_q <= win_id_q;
    end
endmodule

// File: rtl/irq_trig_ctrl.sv
// Module: top of the configurable-trigger interrupt controller. Places one
// source cell per input, masks the status by the enable bits, and feeds the
// arbiter and the register file. Assumes src_in is asynchronous to clk.
module irq_trig_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WA_W-1:0]   reg_waddr,
    input  logic [LANES-1:0]  reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_out
);
    logic [NSRC-1:0] status, edge_pend, en_vec, clr_vec, active;
    trig_e           mode_vec [NSRC];
    logic            rotate_en, win_valid, claim;
    logic [ID_W-1:0] win_id;

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        irqc_src_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_in    (src_in[n]),
            .mode      (mode_vec[n]),
            .clr       (clr_vec[n]),
            .status    (status[n]),
            .edge_pend (edge_pend[n])
        );
    end

    assign active = status & en_vec;
    assign claim  = reg_rd && (reg_waddr == WA_WINNER) && win_valid;

    irqc_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_waddr (reg_waddr),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .status    (status),
        .win_valid (win_valid),
        .win_id    (win_id),
        .en_vec    (en_vec),
        .mode_vec  (mode_vec),
        .clr_vec   (clr_vec),
        .rotate_en (rotate_en),
        .reg_rdata (reg_rdata)
    );

    irqc_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .rotate_en   (rotate_en),
        .claim       (claim),
        .irq_q       (irq_out),
        .win_valid_q (win_valid),
        .win_id_q    (win_id)
    );
endmodule

// File: rtl/irqc_checks.sv
// Module: property checker bound to the controller top.
module irqc_checks
    import irqc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            irq_out,
    input logic            win_valid,
    input logic [ID_W-1:0] win_id,
    input logic [NSRC-1:0] active,
    input logic            rotate_en,
    input logic [NSRC-1:0] edge_pend,
    input logic [NSRC-1:0] clr_vec
);
    AST_IRQ_WIN_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == win_valid); // R8

    AST_WIN_WAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((($past(active) >> win_id) & 64'd1) != 64'd0)); // R7

    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !$past(rotate_en)) |->
        (($past(active) & ((64'd1 << win_id) - 64'd1)) == 64'd0)); // R9

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(edge_pend) & ~$past(clr_vec) & ~edge_pend) == 64'd0)); // R5
endmodule

bind irq_trig_ctrl irqc_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .win_valid (win_valid),
    .win_id    (win_id),
    .active    (active),
    .rotate_en (rotate_en),
    .edge_pend (edge_pend),
    .clr_vec   (clr_vec)
);

// File: tb/tb_irq_trig_ctrl.sv
module tb_irq_trig_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_waddr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    int          n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    irq_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_waddr(reg_waddr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // Vector fields: {index[6], ctrl byte[8], start level, end level, expected status, expected irq}
    localparam logic [17:0] VECS [9] = '{
        {6'd3,  8'h08, 1'b0, 1'b1, 1'b1, 1'b1},  // level enabled
        {6'd3,  8'h00, 1'b0, 1'b1, 1'b1, 1'b0},  // level disabled
        {6'd10, 8'h18, 1'b0, 1'b1, 1'b1, 1'b1},  // rising, rise
        {6'd10, 8'h18, 1'b1, 1'b0, 1'b0, 1'b0},  // rising, fall
        {6'd40, 8'h28, 1'b1, 1'b0, 1'b1, 1'b1},  // falling, fall
        {6'd40, 8'h28, 1'b0, 1'b1, 1'b0, 1'b0},  // falling, rise
        {6'd63, 8'h38, 1'b1, 1'b0, 1'b1, 1'b1},  // either, fall
        {6'd33, 8'h10, 1'b0, 1'b1, 1'b1, 1'b0},  // rising, disabled
        {6'd0,  8'h38, 1'b0, 1'b1, 1'b1, 1'b1}   // either, rise
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_waddr = a[7:2]; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, input bit claim, output logic [31:0] v);
        @(negedge clk);
        reg_waddr = a[7:2]; reg_rd = claim;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic [5:0] idx, input logic [7:0] val);
        wr({idx[5:2], 2'b00} + 8'h40, 32'(val) << (8 * idx[1:0]), 4'b0001 << idx[1:0]);
    endtask

    task automatic clear_all();
        wr(8'h80, 32'hFFFF_FFFF, 4'hF);
        wr(8'h84, 32'hFFFF_FFFF, 4'hF);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [5:0]  idx;
        logic [7:0]  cb;
        logic [31:0] exp_w;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        rd(8'h00, 1'b0, v); chk(v == 32'h0, "R1 winner", v, 32'h0);
        rd(8'h20, 1'b0, v); chk(v == 32'h0, "R1 prio", v, 32'h0);
        rd(8'h24, 1'b0, v); chk(v == 32'h0, "R1 spare", v, 32'h0);
        rd(8'h40, 1'b0, v); chk(v == 32'h0, "R1 ctrl0", v, 32'h0);
        rd(8'h7C, 1'b0, v); chk(v == 32'h0, "R1 ctrl15", v, 32'h0);
        rd(8'h80, 1'b0, v); chk(v == 32'h0, "R1 stat0", v, 32'h0);
        rd(8'h84, 1'b0, v); chk(v == 32'h0, "R1 stat1", v, 32'h0);
        chk(irq_out == 1'b0, "R1 irq", 32'(irq_out), 32'h0);

        // Table walk over trigger modes and enables
        for (int k = 0; k < 9; k++) begin
            idx = VECS[k][17:12];
            cb  = VECS[k][11:4];
            src_in[idx] = VECS[k][3];
            idle(6);
            set_ctrl(idx, cb);
            @(negedge clk);
            src_in[idx] = VECS[k][2];
            idle(6);
            rd(idx[5] ? 8'h84 : 8'h80, 1'b0, v);
            chk(v[idx[4:0]] == VECS[k][1], (cb[5:4] == 2'b00) ? "R3 level status" : "R4 edge status",
                32'(v[idx[4:0]]), 32'(VECS[k][1]));
            chk(irq_out == VECS[k][0], cb[3] ? "R8 irq" : "R7 disabled irq", 32'(irq_out), 32'(VECS[k][0]));
            exp_w = VECS[k][0] ? {24'h0, 2'b10, idx} : 32'h0;
            rd(8'h00, 1'b0, v);
            chk(v == exp_w, "R9 winner", v, exp_w);
            set_ctrl(idx, 8'h00);
            src_in[idx] = 1'b0;
            idle(6);
            clear_all();
        end

        // R2: byte lane write touches only source 5
        wr(8'h44, 32'hAAAA_38AA, 4'b0010);
        rd(8'h44, 1'b0, v); chk(v == 32'h0000_3800, "R2 byte lane", v, 32'h0000_3800);
        set_ctrl(6'd5, 8'h00);

        // R5: write-one-to-clear on an edge bit
        set_ctrl(6'd12, 8'h18);
        @(negedge clk); src_in[12] = 1'b1; idle(6);
        wr(8'h80, 32'h0, 4'hF);
        rd(8'h80, 1'b0, v); chk(v[12] == 1'b1, "R5 write zero keeps", 32'(v[12]), 32'h1);
        wr(8'h80, 32'h0000_1000, 4'hF);
        rd(8'h80, 1'b0, v); chk(v[12] == 1'b0, "R5 write one clears", 32'(v[12]), 32'h0);
        src_in[12] = 1'b0; idle(6);

        // R6: edge detected in the same cycle as its clear
        @(negedge clk); src_in[12] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_waddr = 6'd32; reg_wdata = 32'h0000_1000; reg_be = 4'hF; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_be = '0;
        rd(8'h80, 1'b0, v); chk(v[12] == 1'b1, "R6 set wins over clear", 32'(v[12]), 32'h1);
        set_ctrl(6'd12, 8'h00); src_in[12] = 1'b0; idle(6); clear_all();

        // R3 and R7: level bit not clearable, disable masks but keeps status
        set_ctrl(6'd7, 8'h08);
        @(negedge clk); src_in[7] = 1'b1; idle(6);
        wr(8'h80, 32'h0000_0080, 4'hF);
        rd(8'h80, 1'b0, v); chk(v[7] == 1'b1, "R3 level not cleared", 32'(v[7]), 32'h1);
        chk(irq_out == 1'b1, "R3 level irq stays", 32'(irq_out), 32'h1);
        set_ctrl(6'd7, 8'h00); idle(2);
        chk(irq_out == 1'b0, "R7 disable masks irq", 32'(irq_out), 32'h0);
        rd(8'h80, 1'b0, v); chk(v[7] == 1'b1, "R7 status kept", 32'(v[7]), 32'h1);
        src_in[7] = 1'b0; idle(6);

        // R9 and R10: fixed then rotating priority between sources 5 and 20
        set_ctrl(6'd5, 8'h08); set_ctrl(6'd20, 8'h08);
        @(negedge clk); src_in[5] = 1'b1; src_in[20] = 1'b1; idle(6);
        wr(8'h00, 32'h0000_0014, 4'hF);
        rd(8'h00, 1'b1, v); chk(v == 32'h85, "R9 fixed lowest", v, 32'h85);
        wr(8'h20, 32'h0000_0040, 4'b0001);
        idle(2);
        rd(8'h20, 1'b0, v); chk(v == 32'h40, "R10 rotate bit", v, 32'h40);
        rd(8'h00, 1'b1, v); chk(v == 32'h94, "R10 rotate next", v, 32'h94);
        idle(2);
        rd(8'h00, 1'b0, v); chk(v == 32'h85, "R10 rotate wrap", v, 32'h85);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule